// File: doc/BRIEF.md
# Phase-Steppable Feedback Divider

This block is the divider in the feedback path of a frequency synthesizer loop. It counts cycles of the fast clock and closes one division period every `div_val + 1` cycles, for a modulus between 64 and 2048. A power-of-two postscaler then passes one of every 1, 2, 4 or 8 division periods on to the feedback pulse. Two single-cycle marker pulses are raised at programmable points inside each period. They are placed by matching the counter's upper eight bits, so each marker can be positioned in steps of eight cycles.

Software moves the loop phase one fast-clock cycle at a time. A rising edge on `step_long` makes exactly one later period one cycle longer. A rising edge on `step_short` makes exactly one later period one cycle shorter. A request that arrives while a period is running is held and applied to the next period to begin.

At power-up the feedback follows an external divider. A single-cycle pulse is produced on each active edge of `ext_fb`, and `ext_inv` selects which edge is active. When `use_local` is raised, the block waits for the next active external edge and restarts its own counter on that edge, so the two sources end a period at the same instant. From then on the internal divider drives the feedback.

The controller has three states:
- FOLLOW: the external pulse is forwarded.
- ARMED: the external pulse is still forwarded while the block waits for an edge.
- LOCAL: the internal divider drives the feedback.

The transitions are:
- FOLLOW to ARMED when `use_local` is 1.
- ARMED to LOCAL on an active external edge while `use_local` is 1. This is the reload.
- ARMED to FOLLOW when `use_local` is 0.
- LOCAL to FOLLOW when `use_local` is 0.

Top module: `phase_step_fbdiv`

## Requirements
- R1: In LOCAL state with postscaler code 11, consecutive `fb_pulse` highs are exactly `div_val + 1` cycles apart. The comparison uses the live `div_val`, so a new value already applies to the period that is running.
- R2: The postscaler code `post_sel` sets the ratio between feedback pulses and division periods: 00 gives 8, 01 gives 4, 10 gives 2 and 11 gives 1. After a feedback pulse, the next one comes after exactly ratio × (`div_val` + 1) cycles.
- R3: A 0-to-1 change of `step_long` makes exactly one division period `div_val + 2` cycles long. Holding the bit high has no further effect.
- R4: A 0-to-1 change of `step_short` makes exactly one division period `div_val` cycles long. Holding the bit high has no further effect.
- R5: A step request seen while a period is running changes only the next period to begin. If both kinds of request are pending when that period begins, they cancel and the period keeps its normal length.
- R6: The period starts when the counter returns to 0. In the cycle `8*P + 1` after that, `mark_a` is high for one cycle, where P is `mark_a_pos`. `mark_b` behaves the same way with `mark_b_pos`. With postscaler code 11, this places marker A 8P + 1 cycles after `fb_pulse`.
- R7: In FOLLOW and ARMED states, `fb_pulse` is high for one cycle, in the cycle after `ext_fb` shows an active edge. `ext_inv` = 0 makes the rising edge active and `ext_inv` = 1 makes the falling edge active. The internal divider does not reach the output in these states.
- R8: With `use_local` at 1, the output stays with the external source until an active external edge. That edge produces a pulse and restarts the counter, and the next pulse comes ratio × (`div_val` + 1) cycles later. Dropping `use_local` returns to FOLLOW on the next clock edge.
- R9: While `rst_n` is low, all outputs are 0 and the block is in FOLLOW state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Active-low reset, synchronous |
| div_val | input | 11 | Modulus minus one, 63 to 2047 |
| post_sel | input | 2 | Postscaler code (00:/8, 01:/4, 10:/2, 11:/1) |
| mark_a_pos | input | 8 | Position of marker A, compared with counter bits [10:3] |
| mark_b_pos | input | 8 | Position of marker B, compared with counter bits [10:3] |
| use_local | input | 1 | 1 requests the internal divider, 0 follows the external input |
| ext_inv | input | 1 | Active edge of `ext_fb`: 0 rising, 1 falling |
| ext_fb | input | 1 | External feedback signal, synchronous to `clk` |
| step_short | input | 1 | A rising edge removes one cycle from one period |
| step_long | input | 1 | A rising edge adds one cycle to one period |
| fb_pulse | output | 1 | Single-cycle feedback pulse |
| mark_a | output | 1 | Single-cycle marker A |
| mark_b | output | 1 | Single-cycle marker B |

## Verification
The bench measures the gaps between feedback pulses around each kind of step request:
- A divider that applied a step to the period already running would show the changed gap one period early.
- A divider that acted on the level instead of the edge would keep adding or removing cycles while the bit stays high.
- A divider that let both requests act together, instead of cancelling them, would show one period of the wrong length.

Switchover is checked by requiring that the first internal period is counted from the external edge itself, so a restart that lands one cycle off shifts every later pulse. Each postscaler code is checked from a pulse boundary, and the markers are checked for their exact offset and single-cycle width. Random phases run a cycle-by-cycle model alongside the design and catch any slip in edge detection under polarity changes.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
    typedef enum logic [1:0] {
        S_FOLLOW = 2'd0,
        S_ARMED  = 2'd1,
        S_LOCAL  = 2'd2
    } fb_state_t;

    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_SHORT = 2'd1,
        ADJ_LONG  = 2'd2
    } adj_t;
endpackage

// File: rtl/fbdiv_count.sv
module fbdiv_count
    import fbdiv_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] div_val,
    input  logic             step_short,
    input  logic             step_long,
    input  logic             reload,
    output logic [CNT_W:0]   cnt,
    output logic             tc
);
    localparam int CW = CNT_W + 1;

    logic       short_q, long_q, pend_short, pend_long;
    logic       rise_short, rise_long, want_short, want_long, boundary;
    adj_t       adj_cur;
    logic [CW-1:0] end_val;

    assign rise_short = step_short & ~short_q;
    assign rise_long  = step_long & ~long_q;
    assign want_short = pend_short | rise_short;
    assign want_long  = pend_long | rise_long;

    always_comb begin
        unique case (adj_cur)
            ADJ_SHORT: end_val = {1'b0, div_val} - CW'(1);
            ADJ_LONG:  end_val = {1'b0, div_val} + CW'(1);
            default:   end_val = {1'b0, div_val};
        endcase
    end

    assign tc       = (cnt >= end_val);
    assign boundary = tc | reload;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            short_q    <= 1'b0;
            long_q     <= 1'b0;
            pend_short <= 1'b0;
            pend_long  <= 1'b0;
            adj_cur    <= ADJ_NONE;
        end else begin
            short_q <= step_short;
            long_q  <= step_long;
            if (boundary) begin
                cnt        <= '0;
                pend_short <= 1'b0;
                pend_long  <= 1'b0;
                if (want_short && !want_long)
                    adj_cur <= ADJ_SHORT;
                else if (want_long && !want_short)
                    adj_cur <= ADJ_LONG;
                else
                    adj_cur <= ADJ_NONE;
            end else begin
                cnt        <= cnt + CW'(1);
                pend_short <= want_short;
                pend_long  <= want_long;
            end
        end
    end

    // R1: the counter either restarts at zero or advances by one
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> (cnt == $past(cnt) + CW'(1)));

    // R5: a period boundary consumes every pending request
    a_r5_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (!pend_short && !pend_long));

    // R3 R4: an adjusted period lasts at most one period
    a_r3_adj_single: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !pend_short && !pend_long && !rise_short && !rise_long)
        |=> (adj_cur == ADJ_NONE));
endmodule

// File: rtl/fbdiv_post.sv
module fbdiv_post #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] post_sel,
    input  logic            tc,
    input  logic            reload,
    output logic            fire
);
    localparam int PC_W  = (1 << PS_W) - 1;
    localparam int CODES = 1 << PS_W;

    logic [PC_W-1:0] post_cnt, lim;
    logic            last;

    always_comb begin
        lim = '0;
        for (int i = 0; i < CODES; i++) begin
            if (post_sel == PS_W'(i))
                lim = PC_W'((1 << (PC_W - i)) - 1);
        end
    end

    assign last = (post_cnt >= lim);
    assign fire = tc & last;

    always_ff @(posedge clk) begin
        if (!rst_n)
            post_cnt <= '0;
        else if (reload)
            post_cnt <= '0;
        else if (tc)
            post_cnt <= last ? '0 : post_cnt + PC_W'(1);
    end

    // R2: after a pass-through the postscaler restarts from zero
    a_r2_post_restart: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (post_cnt == '0));
endmodule

// File: rtl/fbdiv_sync.sv
module fbdiv_sync #(
    parameter int CNT_W = 11,
    parameter int POS_W = 8,
    parameter int NUM   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNT_W:0]            cnt,
    input  logic [NUM-1:0][POS_W-1:0] pos,
    output logic [NUM-1:0]            hit
);
    localparam int LSB = CNT_W - POS_W;

    logic in_range, on_grain;
    assign in_range = ~cnt[CNT_W];
    assign on_grain = (cnt[LSB-1:0] == '0);

    for (genvar g = 0; g < NUM; g++) begin : g_mark
        always_ff @(posedge clk) begin
            if (!rst_n)
                hit[g] <= 1'b0;
            else
                hit[g] <= in_range && on_grain && (cnt[CNT_W-1:LSB] == pos[g]);
        end

        // R6: a marker is one cycle wide while its position holds
        a_r6_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> (!hit[g] || (pos[g] != $past(pos[g]))));
    end
endmodule

// File: rtl/fbdiv_ctrl.sv
module fbdiv_ctrl
    import fbdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic use_local,
    input  logic ext_inv,
    input  logic ext_fb,
    input  logic fire,
    output logic reload,
    output logic fb_pulse
);
    fb_state_t state, state_nx;
    logic      ext_q, ext_edge;

    assign ext_edge = (ext_fb ^ ext_inv) & ~(ext_q ^ ext_inv);
    assign reload   = (state == S_ARMED) && use_local && ext_edge;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_FOLLOW: if (use_local) state_nx = S_ARMED;
            S_ARMED: begin
                if (!use_local)    state_nx = S_FOLLOW;
                else if (ext_edge) state_nx = S_LOCAL;
            end
            S_LOCAL:  if (!use_local) state_nx = S_FOLLOW;
            default:  state_nx = S_FOLLOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FOLLOW;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q    <= 1'b0;
            fb_pulse <= 1'b0;
        end else begin
            ext_q    <= ext_fb;
            fb_pulse <= (state == S_LOCAL) ? fire : ext_edge;
        end
    end

    // R8: dropping the request returns to FOLLOW at the next edge
    a_r8_drop_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !use_local |=> (state == S_FOLLOW));

    // R8: entering LOCAL coincides with the pulse of the aligning edge
    a_r8_entry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOCAL && $past(state) == S_ARMED) |-> fb_pulse);

    // R7: without an edge or internal fire there is no pulse
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_edge && !fire) |=> !fb_pulse);
endmodule

// File: rtl/phase_step_fbdiv.sv
module phase_step_fbdiv #(
    parameter int CNT_W = 11,
    parameter int POS_W = 8,
    parameter int PS_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] div_val,
    input  logic [PS_W-1:0]  post_sel,
    input  logic [POS_W-1:0] mark_a_pos,
    input  logic [POS_W-1:0] mark_b_pos,
    input  logic             use_local,
    input  logic             ext_inv,
    input  logic             ext_fb,
    input  logic             step_short,
    input  logic             step_long,
    output logic             fb_pulse,
    output logic             mark_a,
    output logic             mark_b
);
    logic [CNT_W:0]            cnt;
    logic                      tc, fire, reload;
    logic [1:0][POS_W-1:0]     mark_pos;
    logic [1:0]                mark_hit;

    assign mark_pos = {mark_b_pos, mark_a_pos};
    assign mark_a   = mark_hit[0];
    assign mark_b   = mark_hit[1];

    fbdiv_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .div_val(div_val),
        .step_short(step_short), .step_long(step_long),
        .reload(reload), .cnt(cnt), .tc(tc)
    );

    fbdiv_post #(.PS_W(PS_W)) u_post (
        .clk(clk), .rst_n(rst_n), .post_sel(post_sel),
        .tc(tc), .reload(reload), .fire(fire)
    );

    fbdiv_sync #(.CNT_W(CNT_W), .POS_W(POS_W), .NUM(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .pos(mark_pos), .hit(mark_hit)
    );

    fbdiv_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .use_local(use_local), .ext_inv(ext_inv),
        .ext_fb(ext_fb), .fire(fire), .reload(reload), .fb_pulse(fb_pulse)
    );

    // R9: outputs are quiet in the first cycle after reset
    a_r9_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> (!fb_pulse && !mark_a && !mark_b));
endmodule

// File: tb/phase_step_fbdiv_test.sv
module phase_step_fbdiv_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] div_val = 11'd79;
    logic [1:0]  post_sel = 2'b11;
    logic [7:0]  mark_a_pos = 8'd3, mark_b_pos = 8'd6;
    logic        use_local = 1'b0, ext_inv = 1'b0, ext_fb = 1'b0;
    logic        step_short = 1'b0, step_long = 1'b0;
    logic        fb_pulse, mark_a, mark_b;

    int    total = 0, bad = 0, cycles = 0;
    bit    done = 1'b0;
    string cur_tag = "R9";

    phase_step_fbdiv uut (
        .clk(clk), .rst_n(rst_n), .div_val(div_val), .post_sel(post_sel),
        .mark_a_pos(mark_a_pos), .mark_b_pos(mark_b_pos), .use_local(use_local),
        .ext_inv(ext_inv), .ext_fb(ext_fb), .step_short(step_short),
        .step_long(step_long), .fb_pulse(fb_pulse), .mark_a(mark_a), .mark_b(mark_b)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int ratio(input int code);
        return 1 << (3 - code);
    endfunction

    function automatic bit mark_at(input int c, input int p);
        return (c < 2048) && (c % 8 == 0) && (c / 8 == p);
    endfunction

    // reference model: tracks the period, pending requests and source state
    int m_cnt, m_adj, m_post, m_st;
    bit m_ext, m_sq, m_lq, m_ps, m_pl;
    bit e_fb, e_a, e_b;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_adj = 0; m_post = 0; m_st = 0;
            m_ext = 0; m_sq = 0; m_lq = 0; m_ps = 0; m_pl = 0;
            e_fb = 0; e_a = 0; e_b = 0;
        end else begin
            bit edge_s, ws, wl, tcm, fire_m, rel;
            int endv, lim;
            edge_s = (ext_fb ^ ext_inv) && !(m_ext ^ ext_inv);
            ws = m_ps || (step_short && !m_sq);
            wl = m_pl || (step_long && !m_lq);
            endv = int'(div_val) + (m_adj == 2 ? 1 : 0) - (m_adj == 1 ? 1 : 0);
            tcm = (m_cnt >= endv);
            lim = ratio(int'(post_sel)) - 1;
            fire_m = tcm && (m_post >= lim);
            e_a = mark_at(m_cnt, int'(mark_a_pos));
            e_b = mark_at(m_cnt, int'(mark_b_pos));
            e_fb = (m_st == 2) ? fire_m : edge_s;
            rel = (m_st == 1) && use_local && edge_s;
            if (!use_local) m_st = 0;
            else if (m_st == 0) m_st = 1;
            else if (m_st == 1 && edge_s) m_st = 2;
            if (rel) m_post = 0;
            else if (tcm) m_post = (m_post >= lim) ? 0 : m_post + 1;
            if (tcm || rel) begin
                m_cnt = 0;
                m_adj = (ws && !wl) ? 1 : ((wl && !ws) ? 2 : 0);
                m_ps = 0; m_pl = 0;
            end else begin
                m_cnt++;
                m_ps = ws; m_pl = wl;
            end
            m_ext = ext_fb; m_sq = step_short; m_lq = step_long;
        end
    end

    // lockstep comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(fb_pulse == e_fb, cur_tag, "fb_pulse lockstep", fb_pulse, e_fb);
            check(mark_a == e_a, "R6", "mark_a lockstep", mark_a, e_a);
            check(mark_b == e_b, "R6", "mark_b lockstep", mark_b, e_b);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_fb();
        do @(negedge clk); while (!fb_pulse);
    endtask

    task automatic gap(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!fb_pulse);
    endtask

    task automatic expect_gap(input string tag, input int exp);
        int n;
        gap(n);
        check(n == exp, tag, "pulse gap", n, exp);
    endtask

    task automatic quiet(input string tag, input int len);
        int hits = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (fb_pulse) hits++;
        end
        check(hits == 0, tag, "pulses while quiet", hits, 0);
    endtask

    initial begin
        int ka, kb, wa, n;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(!fb_pulse && !mark_a && !mark_b, "R9", "outputs in reset",
              {fb_pulse, mark_a, mark_b}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!fb_pulse, "R9", "fb after reset", fb_pulse, 0);

        // R7: rising edge, then falling edge with inverted polarity
        cur_tag = "R7";
        repeat (5) @(negedge clk);
        ext_fb = 1'b1;
        @(negedge clk); check(fb_pulse == 1'b1, "R7", "rising edge pulse", fb_pulse, 1);
        @(negedge clk); check(fb_pulse == 1'b0, "R7", "pulse width", fb_pulse, 0);
        ext_inv = 1'b1;
        @(negedge clk); check(fb_pulse == 1'b0, "R7", "polarity flip no pulse", fb_pulse, 0);
        ext_fb = 1'b0;
        @(negedge clk); check(fb_pulse == 1'b1, "R7", "falling edge pulse", fb_pulse, 1);
        ext_inv = 1'b0;
        repeat (3) @(negedge clk);

        // R8: arm, stay quiet, align to an edge
        cur_tag = "R8";
        use_local = 1'b1;
        quiet("R8", 200);
        ext_fb = 1'b1;
        @(negedge clk); check(fb_pulse == 1'b1, "R8", "aligning edge pulse", fb_pulse, 1);
        ext_fb = 1'b0;
        expect_gap("R8", 80);

        // R1: modulus from div_val, live update
        cur_tag = "R1";
        expect_gap("R1", 80);
        div_val = 11'd100;
        expect_gap("R1", 101);

        // R6: marker offsets from the feedback pulse
        ka = 0; kb = 0; wa = 0; n = 0;
        do begin
            @(negedge clk); n++;
            if (mark_a) begin wa++; if (ka == 0) ka = n; end
            if (mark_b && kb == 0) kb = n;
        end while (!fb_pulse);
        check(ka == 25, "R6", "mark_a offset", ka, 25);
        check(kb == 49, "R6", "mark_b offset", kb, 49);
        check(wa == 1, "R6", "mark_a width", wa, 1);

        // R2: each postscaler code
        cur_tag = "R2";
        for (int c = 0; c < 4; c++) begin
            post_sel = 2'(c);
            expect_gap("R2", ratio(c) * 101);
        end

        // R3: one longer period, request made mid-period
        cur_tag = "R3";
        step_long = 1'b1;
        expect_gap("R5", 101);
        expect_gap("R3", 102);
        expect_gap("R3", 101);
        step_long = 1'b0;

        // R4: one shorter period
        cur_tag = "R4";
        step_short = 1'b1;
        expect_gap("R4", 101);
        expect_gap("R4", 100);
        expect_gap("R4", 101);
        step_short = 1'b0;

        // R5: both requests cancel
        cur_tag = "R5";
        expect_gap("R5", 101);
        step_short = 1'b1; step_long = 1'b1;
        expect_gap("R5", 101);
        expect_gap("R5", 101);
        step_short = 1'b0; step_long = 1'b0;

        // R8: leave local mode, internal pulses must stop
        cur_tag = "R8";
        use_local = 1'b0;
        quiet("R8", 300);
        ext_fb = 1'b1;
        @(negedge clk); check(fb_pulse == 1'b1, "R8", "external after return", fb_pulse, 1);
        ext_fb = 1'b0;

        // random phase, checked in lockstep by the model
        cur_tag = "R8";
        div_val = 11'd70;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if ($urandom_range(19, 0) == 0) ext_fb = ~ext_fb;
            if ($urandom_range(499, 0) == 0) use_local = ~use_local;
            if ($urandom_range(149, 0) == 0) step_short = ~step_short;
            if ($urandom_range(149, 0) == 0) step_long = ~step_long;
            if ($urandom_range(799, 0) == 0) ext_inv = ~ext_inv;
            if ($urandom_range(999, 0) == 0) div_val = 11'(63 + $urandom_range(99, 0));
            if ($urandom_range(699, 0) == 0) post_sel = 2'($urandom_range(3, 0));
            if ($urandom_range(599, 0) == 0) mark_a_pos = 8'($urandom_range(7, 0));
            if ($urandom_range(599, 0) == 0) mark_b_pos = 8'($urandom_range(7, 0));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule